// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a supervision counter driven by a single 16-bit control word on a plain synchronous write/read port. Software must place a fixed key in the upper byte of every write. A write with any other key is treated as a fault. It raises the system reset output for one cycle and does not change the stored settings. A read always shows a different fixed byte in the upper half, beside the stored control byte.

The counter advances on one of two clock enables. One is a fast enable from the peripheral clock and the other is a slow enable from the auxiliary clock. One of four taps sets the expiry length. In watchdog mode, expiry emits a one-cycle system reset pulse and the count restarts. In interval mode, expiry sets a sticky interrupt flag instead, and counting carries on. Software can stop the count with a hold bit or restart it from zero. Two pin-function bits are only stored and presented on outputs for neighbouring pad logic.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset, rdata_o reads 0x6900, and sys_rst_o and irq_flag_o are low. The control byte is 0x00: watchdog mode, tap 00, fast source, running.
- R2: A write whose bits 15:8 equal 0x5A stores bits 7:0 as the control byte, except bit 3. rdata_o always returns 0x69 in bits 15:8 and the stored byte in bits 7:0.
- R3: A write whose bits 15:8 differ from 0x5A drives sys_rst_o high for exactly the following cycle and leaves the control byte unchanged.
- R4: Bits 1:0 select the period in source ticks: 00 = 2^15, 01 = 2^13, 10 = 2^9, 11 = 2^6. After a clearing write with the source enable held high, expiry is seen in the cycle after the P-th following clock edge.
- R5: With bit 4 = 0 (watchdog mode), expiry drives sys_rst_o high for one cycle and the count restarts from zero, so the next expiry comes a full period later.
- R6: With bit 4 = 1 (interval mode), expiry sets irq_flag_o and does not assert sys_rst_o, and counting continues with the same period.
- R7: irq_flag_o stays set until a cycle with ifg_clr_i high, which clears it at the next edge. A new expiry in the same cycle takes priority over the clear.
- R8: A keyed write with bit 3 = 1 restarts the count from zero. Bit 3 always reads back 0.
- R9: While bit 7 = 1 the count is frozen and no expiry occurs. When the bit is cleared, counting resumes from the held value.
- R10: Bit 2 = 1 counts on slow_ce_i only, and bit 2 = 0 counts on fast_ce_i only.
- R11: Stored bit 5 is driven on nmi_sel_o and stored bit 6 on nmi_edge_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 16 | Write data: key in 15:8, control in 7:0 |
| rdata_o | output | 16 | Read data: 0x69 in 15:8, control byte in 7:0 |
| ifg_clr_i | input | 1 | Clear strobe for the interval flag |
| fast_ce_i | input | 1 | Fast clock enable (source 0) |
| slow_ce_i | input | 1 | Slow clock enable (source 1) |
| sys_rst_o | output | 1 | One-cycle system reset pulse |
| irq_flag_o | output | 1 | Sticky interval interrupt flag |
| nmi_sel_o | output | 1 | Stored pin-function bit |
| nmi_edge_o | output | 1 | Stored edge-select bit |

## Verification
The bench builds the block with its default tap exponents of 15, 13, 9 and 6. Every period is therefore checked at its true length, the longest being 32768 edges. With the enables held high, or toggled on alternate cycles for the slow source, each period can be counted exactly edge by edge. This also exposes off-by-one faults in the tap compare, in the restart after an expiry, and in the resume after a hold.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W  = 8;
  localparam int CTRL_W = 8;
  localparam int DATA_W = KEY_W + CTRL_W;

  localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
  localparam logic [KEY_W-1:0] RD_KEY = 8'h69;

  // field order sets bit positions 7..0
  typedef struct packed {
    logic       hold;      // 7
    logic       nmi_edge;  // 6
    logic       nmi_sel;   // 5
    logic       interval;  // 4
    logic       clr;       // 3, strobe only
    logic       src;       // 2
    logic [1:0] tap;       // 1:0
  } ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              clr_o,
  output logic              bad_key_o
);
  ctrl_t ctrl_q;
  ctrl_t wr_ctrl;
  logic  key_ok;

  assign key_ok    = (wdata_i[DATA_W-1:CTRL_W] == WR_KEY);
  assign wr_ctrl   = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign clr_o     = wr_i & key_ok & wr_ctrl.clr;
  assign bad_key_o = wr_i & ~key_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && key_ok) begin
      ctrl_q     <= wr_ctrl;
      ctrl_q.clr <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {RD_KEY, ctrl_q};
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TAP_EXP0 = 15,
  parameter int TAP_EXP1 = 13,
  parameter int TAP_EXP2 = 9,
  parameter int TAP_EXP3 = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_ce_i,
  input  logic       slow_ce_i,
  input  logic       src_i,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic [1:0] tap_i,
  output logic       expire_o
);
  localparam int M01   = (TAP_EXP0 > TAP_EXP1) ? TAP_EXP0 : TAP_EXP1;
  localparam int M23   = (TAP_EXP2 > TAP_EXP3) ? TAP_EXP2 : TAP_EXP3;
  localparam int CNT_W = (M01 > M23) ? M01 : M23;
  localparam int NTAP  = 4;

  logic [CNT_W-1:0] cnt_q;
  logic [NTAP-1:0]  hit;
  logic             tick;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int E = (g == 0) ? TAP_EXP0 : (g == 1) ? TAP_EXP1 :
                       (g == 2) ? TAP_EXP2 : TAP_EXP3;
    assign hit[g] = &cnt_q[E-1:0];
  end

  assign tick     = ~hold_i & (src_i ? slow_ce_i : fast_ce_i);
  assign expire_o = tick & hit[tap_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i | expire_o) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic interval_i,
  input  logic bad_key_i,
  input  logic ifg_clr_i,
  output logic sys_rst_o,
  output logic irq_flag_o
);
  logic rst_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q  <= bad_key_i | (expire_i & ~interval_i);
      flag_q <= (expire_i & interval_i) | (flag_q & ~ifg_clr_i);
    end
  end

  assign sys_rst_o  = rst_q;
  assign irq_flag_o = flag_q;
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
  import wdt_pkg::*;
#(
  parameter int TAP_EXP0 = 15,
  parameter int TAP_EXP1 = 13,
  parameter int TAP_EXP2 = 9,
  parameter int TAP_EXP3 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ifg_clr_i,
  input  logic              fast_ce_i,
  input  logic              slow_ce_i,
  output logic              sys_rst_o,
  output logic              irq_flag_o,
  output logic              nmi_sel_o,
  output logic              nmi_edge_o
);
  ctrl_t ctrl;
  logic  clr, bad_key, expire_w;

  wdt_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl), .clr_o(clr), .bad_key_o(bad_key)
  );

  wdt_counter #(
    .TAP_EXP0(TAP_EXP0), .TAP_EXP1(TAP_EXP1),
    .TAP_EXP2(TAP_EXP2), .TAP_EXP3(TAP_EXP3)
  ) u_cnt (
    .clk_i, .rst_ni, .fast_ce_i, .slow_ce_i,
    .src_i(ctrl.src), .hold_i(ctrl.hold), .clr_i(clr),
    .tap_i(ctrl.tap), .expire_o(expire_w)
  );

  wdt_expiry u_exp (
    .clk_i, .rst_ni, .expire_i(expire_w), .interval_i(ctrl.interval),
    .bad_key_i(bad_key), .ifg_clr_i, .sys_rst_o, .irq_flag_o
  );

  assign nmi_sel_o  = ctrl.nmi_sel;
  assign nmi_edge_o = ctrl.nmi_edge;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ifg_clr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sys_rst_o,
  input logic              irq_flag_o,
  input logic              expire
);
  logic bad_wr, good_wr;
  assign bad_wr  = wr_i && (wdata_i[DATA_W-1:CTRL_W] != WR_KEY);
  assign good_wr = wr_i && (wdata_i[DATA_W-1:CTRL_W] == WR_KEY);

  p_rd_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:CTRL_W] == RD_KEY);
  p_good_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_wr |=> rdata_o[CTRL_W-1:0] == ($past(wdata_i[CTRL_W-1:0]) & 8'hF7));
  p_bad_key_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> sys_rst_o);
  p_bad_key_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> $stable(rdata_o[CTRL_W-1:0]));
  p_wdog_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !rdata_o[4]) |=> sys_rst_o);
  p_interval_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && rdata_o[4]) |=> irq_flag_o);
  p_rst_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($past(bad_wr) || !$past(rdata_o[4])));
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !ifg_clr_i) |=> irq_flag_o);
  p_clr_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[3]);
  p_hold_no_expiry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] |-> !expire);
endmodule

bind pwd_watchdog wdt_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
  .ifg_clr_i(ifg_clr_i), .rdata_o(rdata_o), .sys_rst_o(sys_rst_o),
  .irq_flag_o(irq_flag_o), .expire(expire_w)
);

// File: tb/pwd_watchdog_tb_top.sv
module pwd_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ifg_clr_i = 1'b0;
  logic        fast_ce_i = 1'b1;
  logic        slow_ce_i = 1'b0;
  logic        sys_rst_o, irq_flag_o, nmi_sel_o, nmi_edge_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwd_watchdog dut_i (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .rdata_o, .ifg_clr_i,
    .fast_ce_i, .slow_ce_i, .sys_rst_o, .irq_flag_o, .nmi_sel_o, .nmi_edge_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  // edges until target output is seen high at a falling edge
  task automatic measure(input int max, input bit want_flag, input bit toggle,
                         output int n, output bit stray);
    n = max + 1; stray = 1'b0;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      ifg_clr_i = 1'b0;
      if (toggle) slow_ce_i = ~slow_ce_i;
      if (want_flag && sys_rst_o) stray = 1'b1;
      if (!want_flag && irq_flag_o) stray = 1'b1;
      if (want_flag ? irq_flag_o : sys_rst_o) begin n = i; break; end
    end
  endtask

  task automatic t_reset;
    chk(rdata_o == 16'h6900, "R1 rdata", int'(rdata_o), 16'h6900);
    chk(!sys_rst_o && !irq_flag_o, "R1 outputs", {sys_rst_o, irq_flag_o}, 0);
  endtask

  task automatic t_taps;
    int n; bit s;
    int per [4] = '{32768, 8192, 512, 64};
    for (int t = 0; t < 4; t++) begin
      wr(16'h5A08 | 16'(t));
      measure(per[t] + 4, 1'b0, 1'b0, n, s);
      chk(n == per[t], "R4 tap period", n, per[t]);
    end
    @(negedge clk_i);
    chk(!sys_rst_o, "R5 pulse width", sys_rst_o, 0);
    measure(80, 1'b0, 1'b0, n, s);
    chk(n == 63, "R5 restart period", n, 63);
  endtask

  task automatic t_regs;
    wr(16'h5A6B);
    chk(rdata_o == 16'h6963, "R2 readback", int'(rdata_o), 16'h6963);
    chk(rdata_o[3] == 1'b0, "R8 clear reads 0", rdata_o[3], 0);
    chk(nmi_sel_o && nmi_edge_o, "R11 pins 11", {nmi_sel_o, nmi_edge_o}, 3);
    wr(16'h5A2B);
    chk(nmi_sel_o && !nmi_edge_o, "R11 pins 10", {nmi_sel_o, nmi_edge_o}, 2);
  endtask

  task automatic t_bad_key;
    wr(16'h5A4B);
    wr(16'hA5F0);
    chk(sys_rst_o, "R3 reset pulse", sys_rst_o, 1);
    chk(rdata_o == 16'h6943, "R3 ctrl kept", int'(rdata_o), 16'h6943);
    @(negedge clk_i);
    chk(!sys_rst_o, "R3 single cycle", sys_rst_o, 0);
    wr(16'h5B00);
    chk(sys_rst_o && rdata_o == 16'h6943, "R3 near key", int'(rdata_o), 16'h6943);
  endtask

  task automatic t_clear;
    int n; bit s;
    wr(16'h5A0B);
    measure(40, 1'b0, 1'b0, n, s);
    chk(n == 41, "R8 no early expiry", n, 41);
    wr(16'h5A0B);
    measure(80, 1'b0, 1'b0, n, s);
    chk(n == 64, "R8 restart from zero", n, 64);
  endtask

  task automatic t_hold;
    int n; bit s;
    wr(16'h5A8B);
    measure(100, 1'b0, 1'b0, n, s);
    chk(n == 101, "R9 held no expiry", n, 101);
    wr(16'h5A03);
    measure(80, 1'b0, 1'b0, n, s);
    chk(n == 64, "R9 resume", n, 64);
  endtask

  task automatic t_source;
    int n; bit s;
    slow_ce_i = 1'b0; fast_ce_i = 1'b1;
    wr(16'h5A0F);
    measure(150, 1'b0, 1'b0, n, s);
    chk(n == 151, "R10 slow ignores fast", n, 151);
    wr(16'h5A0F);
    measure(200, 1'b0, 1'b1, n, s);
    chk(n == 128, "R10 slow ticks", n, 128);
    slow_ce_i = 1'b1; fast_ce_i = 1'b0;
    wr(16'h5A0B);
    measure(150, 1'b0, 1'b0, n, s);
    chk(n == 151, "R10 fast ignores slow", n, 151);
    slow_ce_i = 1'b0; fast_ce_i = 1'b1;
  endtask

  task automatic t_interval;
    int n; bit s; bit held;
    wr(16'h5A1A);
    measure(600, 1'b1, 1'b0, n, s);
    chk(n == 512, "R6 flag period", n, 512);
    chk(!s, "R6 no reset", s, 0);
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (!irq_flag_o || sys_rst_o) held = 1'b0;
    end
    chk(held, "R7 flag sticky", held, 1);
    ifg_clr_i = 1'b1;
    measure(600, 1'b1, 1'b0, n, s);
    chk(n == 492, "R7 clear then R6 continue", n, 492);
    chk(!s, "R6 no reset second", s, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_bad_key();
    t_clear();
    t_hold();
    t_source();
    t_interval();
    t_taps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule